// File: doc/BRIEF.md
# Batch Dispatcher for Pipelined Search Cores

The dispatcher sits between a shared candidate generator and a row of search cores. Each core holds one batch of candidates, as many as its pipeline is deep. When the host asks for a new work block, the dispatcher tells the generator to reload. It then enables the generator and fills the cores in turn, giving each core one candidate per clock until its batch is complete. A core is launched as soon as its batch is complete.

When the last core is full, the generator is paused. The dispatcher then waits until every launched core has reported completion, and only then starts the next round at the first core. Refilling is lockstep on purpose: no core gets new work while any core from the round is still busy.

The search ends in one of two ways. If a core reports a match, the dispatcher stops at once and returns the generator index of the matching candidate. That index is an offset from the start of the work block, not the candidate itself. If the generator runs dry, any partly filled core is still launched, all launched cores are drained, and the dispatcher reports not-found. In both cases a one-cycle result is followed by a return to idle.

Top module: `batch_dispatcher`

## Requirements
- R1: While reset is held and just after it, `busy`, `gen_en`, `gen_init`, `res_valid` and every bit of `core_load` and `core_run` are 0.
- R2: A `start` in idle raises `gen_init` in that same cycle. `busy` and `gen_en` are both high in the following cycle.
- R3: A candidate is consumed only in a cycle with `gen_en` high and `gen_done` low, and exactly one `core_load` bit is set then. Counting candidates from 0 since `gen_init`, candidate j goes to core floor((j mod (NUM_CORES*BATCH)) / BATCH).
- R4: A core's `core_run` bit is high in the same cycle as its BATCH-th load of the round. At most one `core_run` bit is set in any cycle.
- R5: After the last core's batch is loaded, `gen_en` stays low until every launched core has pulsed `core_fin`. Filling resumes at core 0 in the cycle after the last outstanding `core_fin`.
- R6: No core receives a load between its `core_run` and its `core_fin`.
- R7: A `core_fin` with `core_hit` set, arriving while filling or waiting, gives `res_valid` for exactly one cycle in the next cycle. In that cycle `res_found` is 1 and `res_offset` is that core's `core_hit_idx` field. Loading stops from that cycle on, and `busy` is low in the cycle after.
- R8: When several cores report a hit in the same cycle, the lowest-numbered core's index is returned (default `LOW_WINS=1`).
- R9: `gen_done` seen while filling makes `gen_en` low in the next cycle. If the current core holds 1 to BATCH-1 candidates, its `core_run` bit is raised in that cycle with no load. After all launched cores finish, `res_valid` is given with `res_found` equal to 0.
- R10: `start` while `busy` is high has no effect: no `gen_init`, and the running search and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host request to begin a new work block |
| busy | output | 1 | High from the cycle after an accepted start until the cycle after the result |
| gen_init | output | 1 | Tells the generator to reload its work block |
| gen_en | output | 1 | Generator enable; a candidate is taken each cycle it is high and `gen_done` is low |
| gen_done | input | 1 | Generator has no more candidates |
| core_load | output | NUM_CORES | Per-core strobe: the current candidate goes into this core |
| core_run | output | NUM_CORES | Per-core strobe: launch the batch just loaded |
| core_fin | input | NUM_CORES | Per-core pulse: the launched batch is finished |
| core_hit | input | NUM_CORES | Valid with `core_fin`: the batch contained a match |
| core_hit_idx | input | NUM_CORES*IDX_W | Per-core generator index of the matching candidate, core k in bits k*IDX_W upward |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | Result is a match |
| res_offset | output | IDX_W | Offset of the matching candidate from the block start |

## Verification
The hardest situations to reach are the ones where the search ends while other work is still in flight. One is a hit from an early core that arrives while later cores are still being loaded. Another is two cores finishing with hits in the very same cycle. A third is a generator that runs out part way through a batch. The bench reaches these by giving each core model its own latency and sweeping block length and match position together. The short latencies make early cores finish inside the fill. One latency set is chosen so that all cores of a round finish in one cycle, which forces simultaneous hits.

// File: rtl/bd_pkg.sv
package bd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } bd_state_e;

   function automatic int bd_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/bd_fill_seq.sv
module bd_fill_seq
   import bd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int BATCH     = 83
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 active,
   input  logic                 avail,
   output logic [NUM_CORES-1:0] load,
   output logic [NUM_CORES-1:0] run,
   output logic                 round_end
);

   localparam int SEL_W = bd_width(NUM_CORES);
   localparam int CNT_W = bd_width(BATCH);
   localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_CORES - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BATCH - 1);

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;
   logic             last_take;
   logic             part_end;

   assign take      = active && avail;
   assign last_take = take && (cnt_q == CNT_LAST);
   assign part_end  = active && !avail && (cnt_q != '0);
   assign round_end = last_take && (sel_q == SEL_LAST);

   for (genvar k = 0; k < NUM_CORES; k++) begin : g_strobe
      assign load[k] = take && (sel_q == SEL_W'(k));
      assign run[k]  = (last_take || part_end) && (sel_q == SEL_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + SEL_W'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R3: one destination per consumed candidate
   p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load));

   // R4: one launch per cycle at most
   p_run_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(run));

   // R9: a launch without a load only happens when the generator is dry
   p_part_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(run & ~load)) |-> !avail);

endmodule

// File: rtl/bd_pend_track.sv
module bd_pend_track #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic [NUM_CORES-1:0] run,
   input  logic [NUM_CORES-1:0] fin,
   input  logic [NUM_CORES-1:0] load,
   output logic [NUM_CORES-1:0] pend,
   output logic                 drained
);

   logic [NUM_CORES-1:0] pend_nx;

   assign pend_nx = (pend | run) & ~fin;
   assign drained = (pend_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend <= '0;
      else if (clear) pend <= '0;
      else            pend <= pend_nx;
   end

   for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
      // R6: a launched core is never handed new candidates
      p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
         load[k] |-> !pend[k]);
      // R5: completion only arrives from a launched core
      p_fin_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
         fin[k] |-> pend[k]);
   end

endmodule

// File: rtl/bd_result_cap.sv
module bd_result_cap #(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 32,
   parameter bit LOW_WINS  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       arm,
   input  logic [NUM_CORES-1:0]       fin,
   input  logic [NUM_CORES-1:0]       hit,
   input  logic [NUM_CORES*IDX_W-1:0] hit_idx,
   output logic                       hit_any,
   output logic                       found,
   output logic [IDX_W-1:0]           offset
);

   logic [NUM_CORES-1:0] hit_vec;
   logic [IDX_W-1:0]     win_idx;

   assign hit_vec = fin & hit;
   assign hit_any = |hit_vec;

   if (LOW_WINS) begin : g_low
      always_comb begin
         win_idx = '0;
         for (int k = NUM_CORES - 1; k >= 0; k--) begin
            if (hit_vec[k]) win_idx = hit_idx[k*IDX_W +: IDX_W];
         end
      end
   end else begin : g_high
      always_comb begin
         win_idx = '0;
         for (int k = 0; k < NUM_CORES; k++) begin
            if (hit_vec[k]) win_idx = hit_idx[k*IDX_W +: IDX_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found  <= 1'b0;
         offset <= '0;
      end else if (clear) begin
         found  <= 1'b0;
         offset <= '0;
      end else if (arm && hit_any && !found) begin
         found  <= 1'b1;
         offset <= win_idx;
      end
   end

   // R7: a captured match is kept until the next work block
   p_found_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !clear) |=> (found && $stable(offset)));

endmodule

// File: rtl/batch_dispatcher.sv
module batch_dispatcher
   import bd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int BATCH     = 83,
   parameter int IDX_W     = 32,
   parameter bit LOW_WINS  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   output logic                       busy,
   output logic                       gen_init,
   output logic                       gen_en,
   input  logic                       gen_done,
   output logic [NUM_CORES-1:0]       core_load,
   output logic [NUM_CORES-1:0]       core_run,
   input  logic [NUM_CORES-1:0]       core_fin,
   input  logic [NUM_CORES-1:0]       core_hit,
   input  logic [NUM_CORES*IDX_W-1:0] core_hit_idx,
   output logic                       res_valid,
   output logic                       res_found,
   output logic [IDX_W-1:0]           res_offset
);

   initial begin
      assert (NUM_CORES >= 1) else $error("NUM_CORES must be at least 1");
      assert (BATCH >= 2)     else $error("BATCH must be at least 2");
      assert (IDX_W >= 1)     else $error("IDX_W must be at least 1");
   end

   bd_state_e            state_q, state_nx;
   logic                 exhaust_q;
   logic                 accept;
   logic                 filling;
   logic                 round_end;
   logic                 drained;
   logic                 hit_any;
   logic                 arm;
   logic [NUM_CORES-1:0] pend;

   assign accept    = (state_q == ST_IDLE) && start;
   assign filling   = (state_q == ST_FILL);
   assign arm       = filling || (state_q == ST_WAIT);
   assign busy      = (state_q != ST_IDLE);
   assign gen_init  = accept;
   assign gen_en    = filling;
   assign res_valid = (state_q == ST_DONE);

   bd_fill_seq #(
      .NUM_CORES(NUM_CORES),
      .BATCH    (BATCH)
   ) i_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .active   (filling),
      .avail    (!gen_done),
      .load     (core_load),
      .run      (core_run),
      .round_end(round_end)
   );

   bd_pend_track #(
      .NUM_CORES(NUM_CORES)
   ) i_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .run    (core_run),
      .fin    (core_fin),
      .load   (core_load),
      .pend   (pend),
      .drained(drained)
   );

   bd_result_cap #(
      .NUM_CORES(NUM_CORES),
      .IDX_W    (IDX_W),
      .LOW_WINS (LOW_WINS)
   ) i_res (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .arm    (arm),
      .fin    (core_fin),
      .hit    (core_hit),
      .hit_idx(core_hit_idx),
      .hit_any(hit_any),
      .found  (res_found),
      .offset (res_offset)
   );

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_nx = ST_FILL;
         ST_FILL: begin
            if (hit_any)                    state_nx = ST_DONE;
            else if (gen_done || round_end) state_nx = ST_WAIT;
         end
         ST_WAIT: begin
            if (hit_any)      state_nx = ST_DONE;
            else if (drained) state_nx = exhaust_q ? ST_DONE : ST_FILL;
         end
         ST_DONE: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         exhaust_q <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (accept)                               exhaust_q <= 1'b0;
         else if (filling && gen_done && !hit_any) exhaust_q <= 1'b1;
      end
   end

   // R3: candidates are only drawn during a search
   p_en_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |-> busy);

   // R2: an accepted start leads straight into filling
   p_init_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_init |=> (busy && gen_en));

   // R10: a running search cannot be restarted
   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res_valid) |=> busy);

   // R7: the result strobe is a single cycle followed by idle
   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (!res_valid && !busy));

   // R9: a dry generator stops the fill
   p_dry_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && gen_done) |=> !gen_en);

   // R6: nothing is loaded while the pending set is full
   p_full_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&pend) |-> (core_load == '0));

endmodule

// File: tb/test_batch_dispatcher.sv
module test_batch_dispatcher;

   localparam int NC = 3;
   localparam int B  = 4;
   localparam int IW = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           busy, gen_init, gen_en, gen_done;
   logic [NC-1:0]  core_load, core_run, core_fin, core_hit;
   logic [NC*IW-1:0] core_hit_idx;
   logic           res_valid, res_found;
   logic [IW-1:0]  res_offset;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   int gidx     = 0;
   int n_cand   = 0;
   int tgt_a    = -1;
   int tgt_b    = -1;
   int loads_total = 0;
   int t_l11    = 0;
   int t_l12    = 0;
   int lat  [NC];
   int cnt_k[NC];
   int cd   [NC];
   int hidx [NC];
   logic pend_m[NC];
   logic hflag [NC];

   always #2 clk = ~clk;

   batch_dispatcher #(
      .NUM_CORES(NC), .BATCH(B), .IDX_W(IW), .LOW_WINS(1'b1)
   ) i_batch_dispatcher (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .gen_init(gen_init), .gen_en(gen_en), .gen_done(gen_done),
      .core_load(core_load), .core_run(core_run), .core_fin(core_fin),
      .core_hit(core_hit), .core_hit_idx(core_hit_idx),
      .res_valid(res_valid), .res_found(res_found), .res_offset(res_offset)
   );

   assign gen_done = (gidx >= n_cand);

   always_comb begin
      for (int k = 0; k < NC; k++) begin
         core_fin[k] = (cd[k] == 1);
         core_hit[k] = hflag[k];
         core_hit_idx[k*IW +: IW] = IW'(hidx[k]);
      end
   end

   initial begin
      for (int k = 0; k < NC; k++) begin
         lat[k] = 5; cnt_k[k] = 0; cd[k] = 0; hidx[k] = 0;
         pend_m[k] = 1'b0; hflag[k] = 1'b0;
      end
   end

   // generator and core models
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (|core_load) loads_total <= loads_total + 1;
      if (gen_init) gidx <= 0;
      else if (gen_en && !gen_done) gidx <= gidx + 1;
      for (int k = 0; k < NC; k++) begin
         if (gen_init) begin
            cnt_k[k] <= 0;
            hflag[k] <= 1'b0;
         end else begin
            if (core_load[k] && !hflag[k] && (gidx == tgt_a || gidx == tgt_b)) begin
               hflag[k] <= 1'b1;
               hidx[k]  <= gidx;
            end
            if (core_run[k]) cnt_k[k] <= 0;
            else if (core_load[k]) cnt_k[k] <= cnt_k[k] + 1;
            if (core_run[k]) begin
               cd[k] <= lat[k];
               pend_m[k] <= 1'b1;
            end else if (cd[k] > 0) begin
               cd[k] <= cd[k] - 1;
               if (cd[k] == 1) begin
                  pend_m[k] <= 1'b0;
                  hflag[k]  <= 1'b0;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // per-cycle routing and launch checks
   always @(negedge clk) begin
      if (rst_n) begin
         if (|core_load) begin
            int e;
            e = (gidx % (NC*B)) / B;
            chk(core_load == NC'(1 << e), "R3 load routing", int'(core_load), 1 << e);
            chk(gen_en && !gen_done, "R3 load only when drawing", int'(gen_en), 1);
            chk(!pend_m[e], "R6 load into launched core", int'(pend_m[e]), 0);
            if (gidx == 11) t_l11 = cyc;
            if (gidx == 12) t_l12 = cyc;
         end
         if (|core_run) begin
            chk($onehot(core_run), "R4 single launch", int'(core_run), 1);
            for (int k = 0; k < NC; k++) begin
               if (core_run[k]) begin
                  chk((core_load[k] && cnt_k[k] == B-1) ||
                      (!core_load[k] && gen_done && cnt_k[k] > 0 && cnt_k[k] < B),
                      "R4/R9 launch point", cnt_k[k], B-1);
               end
            end
         end
      end
   end

   task automatic run_block(input int n, input int ta, input int tb2, input int poke,
                            input bit exp_found, input int exp_off, input string req);
      int t;
      n_cand = n; tgt_a = ta; tgt_b = tb2;
      @(negedge clk);
      start = 1'b1;
      #1;
      chk(gen_init == 1'b1, "R2 gen_init on start", int'(gen_init), 1);
      @(negedge clk);
      start = 1'b0;
      chk(busy && gen_en, "R2 busy and filling after start", int'(busy) + int'(gen_en), 2);
      t = 0;
      while (!res_valid && t < 3000) begin
         if (t == poke) begin
            start = 1'b1;
            #1;
            chk(gen_init == 1'b0, "R10 start ignored while busy", int'(gen_init), 0);
         end
         @(negedge clk);
         start = 1'b0;
         t++;
      end
      chk(res_valid == 1'b1, {req, " result arrives"}, int'(res_valid), 1);
      chk(res_found == exp_found, {req, " found flag"}, int'(res_found), int'(exp_found));
      if (exp_found)
         chk(int'(res_offset) == exp_off, {req, " offset"}, int'(res_offset), exp_off);
      @(negedge clk);
      chk(!res_valid && !busy, "R7 single result then idle", int'(res_valid) + int'(busy), 0);
      while (pend_m[0] || pend_m[1] || pend_m[2]) @(negedge clk);
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk(!busy && !gen_en && !gen_init && !res_valid && core_load == '0 && core_run == '0,
          "R1 reset outputs", int'(busy) + int'(gen_en) + int'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !gen_en && !gen_init && !res_valid && core_load == '0 && core_run == '0,
          "R1 outputs after reset", int'(busy) + int'(gen_en) + int'(res_valid), 0);

      // R5: refill resumes the cycle after the last completion
      for (int k = 0; k < NC; k++) lat[k] = 5;
      run_block(30, -1, -1, -1, 1'b0, 0, "R9");
      chk(t_l12 - t_l11 == 6, "R5 refill gap", t_l12 - t_l11, 6);

      // R7: hit from core 0 while core 1 is filling stops the loads
      for (int k = 0; k < NC; k++) lat[k] = 2;
      base = loads_total;
      run_block(30, 1, -1, -1, 1'b1, 1, "R7");
      chk(loads_total - base == 6, "R7 loads stop on hit", loads_total - base, 6);

      // R8: simultaneous hits, lowest core wins
      for (int k = 0; k < NC; k++) lat[k] = 3 + B*(NC-1-k);
      run_block(30, 9, 5, -1, 1'b1, 5, "R8");
      run_block(30, 1, 9, -1, 1'b1, 1, "R8");
      run_block(30, 18, 22, -1, 1'b1, 18, "R8");

      // R7: earlier completion wins over lower core number
      lat[0] = 3; lat[1] = 20; lat[2] = 1;
      run_block(30, 5, 9, -1, 1'b1, 9, "R7");

      // R10: start pulses mid-search have no effect
      for (int k = 0; k < NC; k++) lat[k] = 4;
      run_block(20, 17, -1, 3, 1'b1, 17, "R10");
      run_block(20, -1, -1, 15, 1'b0, 0, "R10");

      // sweep of block length and match position
      for (int n = 0; n <= 26; n++) begin
         for (int t = -1; t <= n; t++) begin
            for (int k = 0; k < NC; k++) lat[k] = 1 + ((n + k) % 5);
            base = loads_total;
            run_block(n, t, -1, -1, (t >= 0 && t < n), t, (t >= 0 && t < n) ? "R7" : "R9");
            if (!(t >= 0 && t < n))
               chk(loads_total - base == n, "R9 all candidates loaded", loads_total - base, n);
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule